// File: doc/BRIEF.md
# Paged SRAM Address Extension Unit

This unit widens the 8-bit data address of a small CPU into an 11-bit physical SRAM address. Physical memory is treated as eight pages of 256 bytes each. The logical address always forms the low byte of the result. A 3-bit page number, chosen according to the kind of access under way, forms the top bits.

Three page pointers decide the page. The current pointer serves ordinary operand accesses, the stack pointer serves stack traffic, and the move-immediate pointer serves move-immediate-indirect transfers. A page-mode enable bit sits alongside them. The pointers and the enable bit are written and read through a small register port, and all of them clear on reset. While they are clear, the unit behaves as one flat 256-byte memory. The physical address is purely combinational from the stored state, the access class and the logical address.

Top module: `paged_addr_ext`

## Requirements
- R1: While reset is asserted and after it is released, all three pointers and the enable bit are zero, so every access class maps to page 0.
- R2: `paddr_o[7:0]` always equals `laddr_i`.
- R3: With page mode disabled, ordinary accesses (class 00) map to page 0, whatever the current pointer holds.
- R4: With page mode enabled, ordinary accesses map to the page held in the current pointer.
- R5: Stack accesses (class 01) map to the page held in the stack pointer, with page mode either on or off.
- R6: Move-immediate accesses (class 10) map to the page held in the move-immediate pointer, with page mode either on or off.
- R7: The reserved class 11 maps exactly like an ordinary access.
- R8: The register select codes are 00 for the current pointer, 01 for the stack pointer and 10 for the move-immediate pointer. Each pointer stores only `reg_wdata_i[2:0]`, and its read-back has bits 7:3 equal to zero.
- R9: Select code 11 is the control register. Bit 7 is the page-mode enable, and read-back bits 6:0 are zero.
- R10: A write takes effect at the next rising clock edge. With `reg_we_i` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| acc_class_i | input | 2 | Access class of the current access |
| laddr_i | input | 8 | Logical CPU data address |
| paddr_o | output | 11 | Physical SRAM address |

## Verification
The bench builds the unit with its default widths: an 8-bit logical address, a 3-bit page number and an 8-bit register bus. With these widths all eight pages and every pointer value can be reached in a few thousand random steps.

Random writes carry full 8-bit data, so the masking of the unused pointer bits is exercised, and so is a control write with bit 7 clear but other bits set. Directed steps cover the cases the random steps may miss:
- stack and move-immediate accesses taken with paging both off and on;
- the reserved access class;
- the flat-memory state that reset leaves.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;
  localparam int unsigned LADDR_W = 8;
  localparam int unsigned PAGE_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned PADDR_W = LADDR_W + PAGE_W;

  typedef enum logic [1:0] {
    ACC_ORD = 2'b00,
    ACC_STK = 2'b01,
    ACC_MVI = 2'b10,
    ACC_RSV = 2'b11
  } acc_class_e;

  typedef enum logic [1:0] {
    SEL_CUR = 2'b00,
    SEL_STK = 2'b01,
    SEL_MVI = 2'b10,
    SEL_CTL = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/page_regfile.sv
module page_regfile
  import paged_addr_pkg::*;
#(
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned EB = EN_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [PW-1:0] cur_pg_o,
  output logic [PW-1:0] stk_pg_o,
  output logic [PW-1:0] mvi_pg_o,
  output logic          pg_en_o
);
  localparam int unsigned NPTR = 3;

  logic [PW-1:0] ptr_q [NPTR];
  logic          en_q;

  // one storage slot per pointer select code
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ptr_q[g] <= '0;
      else if (we_i && (sel_i == 2'(g)))        ptr_q[g] <= wdata_i[PW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_q <= 1'b0;
    else if (we_i && (sel_i == 2'(SEL_CTL)))       en_q <= wdata_i[EB];
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      2'(SEL_CUR): rdata_o[PW-1:0] = ptr_q[0];
      2'(SEL_STK): rdata_o[PW-1:0] = ptr_q[1];
      2'(SEL_MVI): rdata_o[PW-1:0] = ptr_q[2];
      default:     rdata_o[EB]     = en_q;
    endcase
  end

  assign cur_pg_o = ptr_q[0];
  assign stk_pg_o = ptr_q[1];
  assign mvi_pg_o = ptr_q[2];
  assign pg_en_o  = en_q;
endmodule

// File: rtl/page_select.sv
module page_select
  import paged_addr_pkg::*;
#(
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned AW = LADDR_W
) (
  input  logic [1:0]    class_i,
  input  logic          pg_en_i,
  input  logic [PW-1:0] cur_pg_i,
  input  logic [PW-1:0] stk_pg_i,
  input  logic [PW-1:0] mvi_pg_i,
  input  logic [AW-1:0] laddr_i,
  output logic [PW+AW-1:0] paddr_o
);
  logic [PW-1:0] page;

  always_comb begin
    unique case (class_i)
      2'(ACC_STK): page = stk_pg_i;
      2'(ACC_MVI): page = mvi_pg_i;
      default:     page = pg_en_i ? cur_pg_i : '0;  // ordinary and reserved
    endcase
  end

  assign paddr_o = {page, laddr_i};
endmodule

// File: rtl/paged_addr_ext.sv
module paged_addr_ext
  import paged_addr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [1:0]         acc_class_i,
  input  logic [LADDR_W-1:0] laddr_i,
  output logic [PADDR_W-1:0] paddr_o
);
  logic [PAGE_W-1:0] cur_pg, stk_pg, mvi_pg;
  logic              pg_en;

  page_regfile #(.PW(PAGE_W), .DW(DATA_W), .EB(EN_BIT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .cur_pg_o (cur_pg),
    .stk_pg_o (stk_pg),
    .mvi_pg_o (mvi_pg),
    .pg_en_o  (pg_en)
  );

  page_select #(.PW(PAGE_W), .AW(LADDR_W)) u_sel (
    .class_i  (acc_class_i),
    .pg_en_i  (pg_en),
    .cur_pg_i (cur_pg),
    .stk_pg_i (stk_pg),
    .mvi_pg_i (mvi_pg),
    .laddr_i  (laddr_i),
    .paddr_o  (paddr_o)
  );
endmodule

// File: rtl/paged_addr_ext_chk.sv
module paged_addr_ext_chk
  import paged_addr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [1:0]         reg_sel_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [1:0]         acc_class_i,
  input logic [LADDR_W-1:0] laddr_i,
  input logic [PADDR_W-1:0] paddr_o,
  input logic               pg_en
);
  // R2
  low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[LADDR_W-1:0] == laddr_i);

  // R3
  flat_ord_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_en && acc_class_i == 2'(ACC_ORD)) |-> paddr_o[PADDR_W-1:LADDR_W] == '0);

  // R5
  stk_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'(SEL_STK)) |=>
      (acc_class_i == 2'(ACC_STK) -> paddr_o[PADDR_W-1:LADDR_W] == $past(reg_wdata_i[PAGE_W-1:0])));

  // R6
  mvi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'(SEL_MVI)) |=>
      (acc_class_i == 2'(ACC_MVI) -> paddr_o[PADDR_W-1:LADDR_W] == $past(reg_wdata_i[PAGE_W-1:0])));

  // R8
  ptr_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i != 2'(SEL_CTL)) |-> reg_rdata_o[DATA_W-1:PAGE_W] == '0);

  // R9
  ctl_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'(SEL_CTL)) |-> reg_rdata_o[EN_BIT-1:0] == '0);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ($stable(acc_class_i) -> $stable(paddr_o[PADDR_W-1:LADDR_W])));
endmodule

bind paged_addr_ext paged_addr_ext_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .acc_class_i (acc_class_i),
  .laddr_i     (laddr_i),
  .paddr_o     (paddr_o),
  .pg_en       (pg_en)
);

// File: tb/sim_paged_addr_ext.sv
`timescale 1ns/1ps
module sim_paged_addr_ext;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [1:0]  acc_class_i = '0;
  logic [7:0]  laddr_i = '0;
  logic [10:0] paddr_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  // bench model of register state
  logic [2:0] m_cur = '0, m_stk = '0, m_mvi = '0;
  logic       m_en = 1'b0;

  always #2.5 clk_i = ~clk_i;

  paged_addr_ext u0 (.*);

  function automatic logic [10:0] exp_paddr(input logic [1:0] c, input logic [7:0] a);
    logic [2:0] p;
    case (c)
      2'b01:   p = m_stk;
      2'b10:   p = m_mvi;
      default: p = m_en ? m_cur : 3'd0;
    endcase
    return {p, a};
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] s);
    case (s)
      2'b00:   return {5'd0, m_cur};
      2'b01:   return {5'd0, m_stk};
      2'b10:   return {5'd0, m_mvi};
      default: return {m_en, 7'd0};
    endcase
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string class_req(input logic [1:0] c);
    case (c)
      2'b01:   return "R5";
      2'b10:   return "R6";
      2'b11:   return "R7";
      default: return m_en ? "R4" : "R3";
    endcase
  endfunction

  // drive at negedge, check combinational outputs, commit model at posedge
  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] wd,
                      input logic [1:0] cls, input logic [7:0] la);
    @(negedge clk_i);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    acc_class_i = cls; laddr_i = la;
    #1;
    check(class_req(cls), paddr_o, exp_paddr(cls, la));
    check((sel == 2'b11) ? "R9" : "R8", {3'd0, reg_rdata_o}, {3'd0, exp_rdata(sel)});
    if (we) begin
      case (sel)
        2'b00: m_cur = wd[2:0];
        2'b01: m_stk = wd[2:0];
        2'b10: m_mvi = wd[2:0];
        default: m_en = wd[7];
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    // R1: during reset every class maps to page 0
    #3;
    for (int c = 0; c < 4; c++) begin
      acc_class_i = 2'(c); laddr_i = 8'hA5; #1;
      check("R1", paddr_o, {3'd0, 8'hA5});
    end
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int c = 0; c < 4; c++) step(1'b0, 2'(c), 8'h00, 2'(c), 8'h3C); // R1 after release
    // R3: current pointer ignored while paging off
    step(1'b1, 2'b00, 8'hFD, 2'b00, 8'h10);
    step(1'b0, 2'b00, 8'h00, 2'b00, 8'h11);   // R8 read back 05
    step(1'b0, 2'b00, 8'h00, 2'b11, 8'h12);   // R7
    // R5/R6 with paging off
    step(1'b1, 2'b01, 8'hFF, 2'b01, 8'h20);
    step(1'b1, 2'b10, 8'hF2, 2'b01, 8'h21);
    step(1'b0, 2'b10, 8'h00, 2'b10, 8'h22);
    // R9: control write with only low bits set keeps paging off
    step(1'b1, 2'b11, 8'h7F, 2'b00, 8'h30);
    step(1'b0, 2'b11, 8'h00, 2'b00, 8'h31);
    // enable paging: R4, R7, R5, R6 with paging on
    step(1'b1, 2'b11, 8'h80, 2'b00, 8'h40);
    step(1'b0, 2'b11, 8'h00, 2'b00, 8'h41);
    step(1'b0, 2'b00, 8'h00, 2'b11, 8'h42);
    step(1'b0, 2'b01, 8'h00, 2'b01, 8'h43);
    step(1'b0, 2'b10, 8'h00, 2'b10, 8'hFF);
    // R10: write is visible only from the next step
    step(1'b1, 2'b00, 8'h03, 2'b00, 8'h50);
    step(1'b0, 2'b00, 8'h00, 2'b00, 8'h51);
    // random mix, R2 and R8 covered by every step
    for (int i = 0; i < 3000; i++) begin
      logic we;
      we = ($urandom % 4) == 0;
      step(we, 2'($urandom), 8'($urandom), 2'($urandom), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule